// File: doc/BRIEF.md
# Pipelined RGB to YCbCr Converter

This block turns a stream of 8-bit-per-channel RGB pixels into luma and two chroma samples with a fixed integer transform. One pixel can enter on every clock cycle, qualified by a valid flag. Three cycles later the matching Y, U and V bytes appear with their own valid flag. There is no stall path, so the block sits directly in a pixel pipeline that never pauses.

Each output is a weighted sum of R, G and B. The weights are fixed signed integers with 13 fractional bits. The sum is held as a signed value and shifted right arithmetically by 13 places. A constant offset is then added and the result is clamped to one byte. The results are exact to the bit, so any integer model of the same formula gives identical bytes.

Top module: `rgb_ycc_conv`

## Requirements
- R1: `out_y` equals 16 + ((2104·R + 4130·G + 802·B) >>> 13).
- R2: `out_u` equals 128 + ((3598·B − 1217·R − 2382·G) >>> 13).
- R3: `out_v` equals 128 + ((3598·R − 3015·G − 583·B) >>> 13).
- R4: The shift acts on the signed sum before the offset is added, so a negative sum rounds toward minus infinity. Pure red (255,0,0) gives U = 90, and white (255,255,255) gives U = 127.
- R5: `out_valid` is high in the cycle exactly three clock edges after the edge that sampled `in_valid` high, and low otherwise. The output bytes belong to that same pixel.
- R6: While `rst_n` is low, `out_valid` is low. Pixels in flight when reset is asserted never appear at the output. After release, `out_valid` stays low until a new pixel has passed through all three stages.
- R7: Every output byte is clamped to 0..255 after the offset. Y therefore always lies in 16..235, and U and V lie in 15..240.
- R8: While `out_valid` is low, `out_y`, `out_u` and `out_v` keep the values of the last valid pixel, including across a reset.
- R9: Pixels presented on consecutive cycles come out on consecutive cycles, with no bubbles, at one pixel per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears only the valid pipeline |
| in_valid | input | 1 | Input pixel qualifier |
| in_r | input | 8 | Red sample, unsigned |
| in_g | input | 8 | Green sample, unsigned |
| in_b | input | 8 | Blue sample, unsigned |
| out_valid | output | 1 | Output sample qualifier |
| out_y | output | 8 | Luma |
| out_u | output | 8 | Blue-difference chroma |
| out_v | output | 8 | Red-difference chroma |

## Verification
The assertions check on every cycle the three-cycle alignment of the valid flag, the quiet output after reset release, the legal range of each output byte, and that the data holds steady while no pixel is valid. Bit exactness of the three formulas can only be shown by the bench's scenarios. These compare each output against an integer model over directed colours and random pixel streams. The bench scenarios also cover the floor rounding of negative chroma sums, the dropping of pixels caught in flight by a mid-stream reset, and full-rate bursts.

// File: rtl/rgb_ycc_pkg.sv
package rgb_ycc_pkg;

  // Coefficient word: signed, with 13 fractional bits.
  localparam int COEF_W = 14;
  localparam int FRAC_W = 13;
  localparam int N_CH   = 3;   // output channels: 0 = Y, 1 = U, 2 = V
  localparam int N_SRC  = 3;   // input components: 0 = R, 1 = G, 2 = B

  typedef logic signed [COEF_W-1:0] coef_t;

  // Weight that input component src contributes to output channel ch.
  function automatic coef_t coef(input int ch, input int src);
    coef_t k;
    k = '0;
    case (ch)
      0: case (src)
           0: k = coef_t'(2104);
           1: k = coef_t'(4130);
           default: k = coef_t'(802);
         endcase
      1: case (src)
           0: k = coef_t'(-1217);
           1: k = coef_t'(-2382);
           default: k = coef_t'(3598);
         endcase
      default: case (src)
           0: k = coef_t'(3598);
           1: k = coef_t'(-3015);
           default: k = coef_t'(-583);
         endcase
    endcase
    return k;
  endfunction

  // Constant added after the shift.
  function automatic int offset(input int ch);
    return (ch == 0) ? 16 : 128;
  endfunction

endpackage

// File: rtl/rgb_ycc_valid_pipe.sv
module rgb_ycc_valid_pipe #(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic [STAGES-1:0] stage_vld
);

  logic [STAGES-1:0] vld_q;
  logic [STAGES-1:0] vld_d;

  always_comb begin
    vld_d = {vld_q[STAGES-2:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign stage_vld = vld_q;

endmodule

// File: rtl/rgb_ycc_clamp.sv
module rgb_ycc_clamp #(
  parameter int ACC_W = 24,
  parameter int OUT_W = 8
) (
  input  logic signed [ACC_W-1:0] val,
  output logic        [OUT_W-1:0] res
);

  localparam logic signed [ACC_W-1:0] MAX_V = ACC_W'((1 << OUT_W) - 1);

  always_comb begin
    if (val < 0) begin
      res = '0;
    end else if (val > MAX_V) begin
      res = '1;
    end else begin
      res = val[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/rgb_ycc_lane.sv
module rgb_ycc_lane
  import rgb_ycc_pkg::*;
#(
  parameter int    PIX_W  = 8,
  parameter int    ACC_W  = 24,
  parameter coef_t K_R    = '0,
  parameter coef_t K_G    = '0,
  parameter coef_t K_B    = '0,
  parameter int    OFFSET = 0
) (
  input  logic                       clk,
  input  logic                       en_mul,
  input  logic                       en_sum,
  input  logic                       en_out,
  input  logic [N_SRC-1:0][PIX_W-1:0] pix,
  output logic [PIX_W-1:0]           res
);

  localparam coef_t                   K [N_SRC] = '{K_R, K_G, K_B};
  localparam logic signed [ACC_W-1:0] OFF_EXT   = ACC_W'(OFFSET);

  // Stage 1: one product per input component.
  logic signed [ACC_W-1:0] prod_d [N_SRC];
  logic signed [ACC_W-1:0] prod_q [N_SRC];

  for (genvar t = 0; t < N_SRC; t++) begin : g_term
    logic signed [ACC_W-1:0] pix_ext;
    logic signed [ACC_W-1:0] coef_ext;

    assign pix_ext  = $signed({{(ACC_W-PIX_W){1'b0}}, pix[t]});
    assign coef_ext = $signed({{(ACC_W-COEF_W){K[t][COEF_W-1]}}, K[t]});

    always_comb begin
      prod_d[t] = pix_ext * coef_ext;
    end

    always_ff @(posedge clk) begin
      if (en_mul) begin
        prod_q[t] <= prod_d[t];
      end
    end
  end

  // Stage 2: signed sum of the products.
  logic signed [ACC_W-1:0] sum_d;
  logic signed [ACC_W-1:0] sum_q;

  always_comb begin
    sum_d = prod_q[0] + prod_q[1] + prod_q[2];
  end

  always_ff @(posedge clk) begin
    if (en_sum) begin
      sum_q <= sum_d;
    end
  end

  // Stage 3: floor shift, offset, clamp to one byte.
  logic signed [ACC_W-1:0] shifted;
  logic signed [ACC_W-1:0] biased;
  logic        [PIX_W-1:0] clamped;
  logic        [PIX_W-1:0] res_q;

  always_comb begin
    shifted = sum_q >>> FRAC_W;
    biased  = shifted + OFF_EXT;
  end

  rgb_ycc_clamp #(
    .ACC_W (ACC_W),
    .OUT_W (PIX_W)
  ) u_clamp (
    .val (biased),
    .res (clamped)
  );

  always_ff @(posedge clk) begin
    if (en_out) begin
      res_q <= clamped;
    end
  end

  assign res = res_q;

endmodule

// File: rtl/rgb_ycc_conv.sv
module rgb_ycc_conv
  import rgb_ycc_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_r,
  input  logic [PIX_W-1:0] in_g,
  input  logic [PIX_W-1:0] in_b,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_y,
  output logic [PIX_W-1:0] out_u,
  output logic [PIX_W-1:0] out_v
);

  localparam int STAGES = 3;
  localparam int ACC_W  = PIX_W + COEF_W + 2;

  logic [STAGES-1:0]             stage_vld;
  logic [N_SRC-1:0][PIX_W-1:0]   pix;
  logic [PIX_W-1:0]              lane_res [N_CH];

  assign pix[0] = in_r;
  assign pix[1] = in_g;
  assign pix[2] = in_b;

  rgb_ycc_valid_pipe #(
    .STAGES (STAGES)
  ) u_vpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .stage_vld (stage_vld)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_lane
    rgb_ycc_lane #(
      .PIX_W  (PIX_W),
      .ACC_W  (ACC_W),
      .K_R    (coef(ch, 0)),
      .K_G    (coef(ch, 1)),
      .K_B    (coef(ch, 2)),
      .OFFSET (offset(ch))
    ) u_lane (
      .clk    (clk),
      .en_mul (in_valid),
      .en_sum (stage_vld[0]),
      .en_out (stage_vld[1]),
      .pix    (pix),
      .res    (lane_res[ch])
    );
  end

  assign out_valid = stage_vld[STAGES-1];
  assign out_y     = lane_res[0];
  assign out_u     = lane_res[1];
  assign out_v     = lane_res[2];

endmodule

// File: rtl/rgb_ycc_conv_chk.sv
module rgb_ycc_conv_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_y,
  input logic [PIX_W-1:0] out_u,
  input logic [PIX_W-1:0] out_v
);

  logic [1:0] cyc_q;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
      if (out_valid) seen_q <= 1'b1;
    end
  end

  // R5, R9: the valid flag is the input flag three edges later.
  a_r5_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R6: quiet output until a fresh pixel has crossed every stage.
  a_r6_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != 2'd3) |-> !out_valid);

  // R7: luma range.
  a_r7_luma_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_y >= PIX_W'(16) && out_y <= PIX_W'(235)));

  // R7: chroma range.
  a_r7_chroma_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_u >= PIX_W'(15) && out_u <= PIX_W'(240) &&
                   out_v >= PIX_W'(15) && out_v <= PIX_W'(240)));

  // R8: data holds while nothing valid is presented.
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !out_valid) |-> ($stable(out_y) && $stable(out_u) && $stable(out_v)));

endmodule

bind rgb_ycc_conv rgb_ycc_conv_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_y     (out_y),
  .out_u     (out_u),
  .out_v     (out_v)
);

// File: tb/rgb_ycc_conv_tb.sv
`timescale 1ns/1ps
module rgb_ycc_conv_tb;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_r, in_g, in_b;
  logic       out_valid;
  logic [7:0] out_y, out_u, out_v;

  int checks;
  int fails;
  int outv_cnt;
  bit done;

  // Expected-value pipeline, index 2 is due at the next sample.
  logic       p_v  [3];
  logic [7:0] p_y  [3];
  logic [7:0] p_u  [3];
  logic [7:0] p_vv [3];
  bit         p_r4 [3];

  bit         have_last;
  logic [7:0] last_y, last_u, last_v;

  rgb_ycc_conv u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_r      (in_r),
    .in_g      (in_g),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_y     (out_y),
    .out_u     (out_u),
    .out_v     (out_v)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int clamp8(input int x);
    if (x < 0) return 0;
    if (x > 255) return 255;
    return x;
  endfunction

  function automatic logic [7:0] ref_y(input int r, input int g, input int b);
    int s;
    s = 2104 * r + 4130 * g + 802 * b;
    return 8'(clamp8(16 + (s >>> 13)));
  endfunction

  function automatic logic [7:0] ref_u(input int r, input int g, input int b);
    int s;
    s = 3598 * b - 1217 * r - 2382 * g;
    return 8'(clamp8(128 + (s >>> 13)));
  endfunction

  function automatic logic [7:0] ref_v(input int r, input int g, input int b);
    int s;
    s = 3598 * r - 3015 * g - 583 * b;
    return 8'(clamp8(128 + (s >>> 13)));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_pipe();
    for (int i = 0; i < 3; i++) begin
      p_v[i] = 1'b0; p_y[i] = '0; p_u[i] = '0; p_vv[i] = '0; p_r4[i] = 1'b0;
    end
  endtask

  task automatic sample_outputs();
    check(out_valid == p_v[2], "R5 valid", int'(out_valid), int'(p_v[2]));
    if (out_valid && p_v[2]) begin
      outv_cnt++;
      check(out_y == p_y[2], "R1 luma", out_y, p_y[2]);
      check(out_u == p_u[2], p_r4[2] ? "R4 floor chroma" : "R2 blue chroma", out_u, p_u[2]);
      check(out_v == p_vv[2], "R3 red chroma", out_v, p_vv[2]);
      check(out_y >= 16 && out_y <= 235 && out_u >= 15 && out_u <= 240 &&
            out_v >= 15 && out_v <= 240, "R7 range", out_y, 16);
      have_last = 1'b1;
      last_y = out_y; last_u = out_u; last_v = out_v;
    end else if (!out_valid && have_last) begin
      check(out_y == last_y && out_u == last_u && out_v == last_v,
            "R8 hold", out_y, last_y);
    end
  endtask

  // One clock: sample at the falling edge, then drive the next pixel.
  task automatic step(input bit v, input int r, input int g, input int b,
                      input bit r4 = 1'b0, input int u_const = 0);
    @(negedge clk);
    sample_outputs();
    for (int i = 2; i > 0; i--) begin
      p_v[i] = p_v[i-1]; p_y[i] = p_y[i-1]; p_u[i] = p_u[i-1];
      p_vv[i] = p_vv[i-1]; p_r4[i] = p_r4[i-1];
    end
    in_valid = v;
    in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
    p_v[0]  = v;
    p_y[0]  = ref_y(r, g, b);
    p_u[0]  = r4 ? 8'(u_const) : ref_u(r, g, b);
    p_vv[0] = ref_v(r, g, b);
    p_r4[0] = r4;
  endtask

  task automatic reset_pulse();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    clear_pipe();
    #1;
    check(out_valid == 1'b0, "R6 reset assert", int'(out_valid), 0);
    repeat (2) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R6 in reset", int'(out_valid), 0);
    end
    rst_n = 1'b1;
  endtask

  initial begin
    #(4.0 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    int cnt0;
    seed = 32'h1D5E_A7C3;
    void'($urandom(seed));
    checks = 0; fails = 0; outv_cnt = 0; done = 1'b0; have_last = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_r = '0; in_g = '0; in_b = '0;
    clear_pipe();
    #1;
    check(out_valid == 1'b0, "R6 power-on", int'(out_valid), 0);
    reset_pulse();

    // Idle after release: no stray valid (R6).
    repeat (4) step(1'b0, 0, 0, 0);

    // Directed colours.
    step(1'b1, 0, 0, 0);
    step(1'b1, 255, 255, 255, 1'b1, 127);  // R4 white, sum -255
    step(1'b1, 255, 0, 0, 1'b1, 90);       // R4 pure red
    step(1'b1, 0, 255, 0);
    step(1'b1, 0, 0, 255);
    step(1'b1, 0, 255, 255);
    step(1'b1, 1, 0, 0);
    step(1'b1, 255, 0, 255);
    repeat (4) step(1'b0, 7, 7, 7);        // R8 idle hold

    // R9 burst at full rate.
    cnt0 = outv_cnt;
    for (int i = 0; i < 20; i++) step(1'b1, i * 13, 255 - i * 11, i * 7);
    repeat (3) step(1'b0, 0, 0, 0);
    check(outv_cnt - cnt0 == 20, "R9 burst count", outv_cnt - cnt0, 20);

    // Reset with pixels in flight (R6): they must vanish.
    step(1'b1, 10, 20, 30);
    step(1'b1, 200, 100, 50);
    reset_pulse();
    repeat (5) step(1'b0, 0, 0, 0);

    // Random stream, mostly valid.
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, $urandom % 256, $urandom % 256, $urandom % 256);
    end
    repeat (4) step(1'b0, 0, 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule